// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block sequences a successive-approximation analog-to-digital conversion one bit at a time. A conversion request arms it. The request's rising edge raises the busy flag and clears the trial word. The step sequence starts only once the request has returned low. From then on, every accepted step tick produces one pulse on the conversion clock output. The first pulse places the most significant bit in its trial state. Each later pulse keeps or drops the pending bit according to the comparator and places the next lower bit in trial. An external DAC is driven by the trial word, and an external comparator answers whether the analog input is at or above it.

Results are presented negative-true. The parallel word is the bitwise inverse of the trial word. A serial NRZ bit carries the inverse of each decided bit, most significant first, and changes together with the conversion clock. A resolution select, sampled when the request rises, can stop the sequence after 10 or 8 bits; bits that were not converted stay at their idle state. Busy falls one system cycle after the final pulse, so the result is already settled when the falling edge of busy is used to latch it.

The block runs on a single free-running system clock. A step-enable input sets the conversion pace, standing in for a gated clock.

Top module: `sar_conv_ctrl`

## Requirements
- R1: While reset is held, and in the cycle after it, busy is 0, conv_clk is 0, trial is all zeros, par_out is all ones and ser_out is 1.
- R2: A 0-to-1 change of conv_start seen while idle sets busy in the next cycle, with trial all zeros and par_out all ones.
- R3: After conv_start returns to 0, each step_en tick produces exactly one cycle of conv_clk high, for exactly N+1 ticks, where N is the selected resolution. conv_clk is 0 whenever busy is 0.
- R4: In the cycle of the first conv_clk pulse, trial has only its most significant bit (bit WIDTH-1) set.
- R5: With a comparator that answers 1 when the analog code is at or above trial, a 12-bit conversion leaves par_out equal to the bitwise inverse of the analog code.
- R6: In the cycle of conv_clk pulse k (k of 2 or more), ser_out is the inverse of the decided bit WIDTH-k+1. In the cycle of pulse 1 it is 1. ser_out changes in no cycle in which conv_clk is 0.
- R7: res_sel is sampled at the request's rising edge. 2'b01 selects 10 bits, 2'b10 selects 8 bits, and 2'b00 and 2'b11 select 12 bits. The unconverted low bits of par_out read 1.
- R8: busy falls exactly one cycle after the cycle of the last conv_clk pulse, and par_out in that cycle equals its value in the last pulse cycle.
- R9: A rising or falling edge of conv_start while busy is 1 is ignored, including in the last busy cycle. No new conversion follows, and the result is unaffected.
- R10: step_en ticks that arrive while conv_start is still 1 after the request produce no conv_clk pulse and leave trial at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_start | input | 1 | Conversion request; rising edge arms, return to 0 releases the sequence |
| step_en | input | 1 | Step tick that paces the bit trials |
| cmp_keep | input | 1 | Comparator decision: 1 when the analog input is at or above the trial word |
| res_sel | input | 2 | Resolution select: 01 gives 10 bits, 10 gives 8 bits, otherwise 12 bits |
| trial | output | WIDTH | Positive-true trial word for the feedback DAC |
| busy | output | 1 | High from request to end of conversion |
| conv_clk | output | 1 | High for one cycle for each accepted step |
| ser_out | output | 1 | Negative-true serial NRZ bit, MSB first |
| par_out | output | WIDTH | Negative-true parallel result |

## Verification
The final decision with its one-cycle settle and a new request's rising edge can land in the same cycle. The bench raises conv_start in the cycle where the last conversion-clock pulse is seen. It then requires busy to fall one cycle later and stay low while the request is held high. In a second case, a request pulse is sent in the middle of a run, and the bench requires the pulse count and the result to match an ideal comparator model as if no pulse had come.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_ARMED  = 2'd1,
        PH_RUN    = 2'd2,
        PH_SETTLE = 2'd3
    } phase_e;

    // Resolution decode: 01 -> first short length, 10 -> second, else full
    function automatic int res_bits(input logic [1:0] sel, input int full,
                                    input int short_a, input int short_b);
        case (sel)
            2'b01:   return short_a;
            2'b10:   return short_b;
            default: return full;
        endcase
    endfunction

endpackage

// File: rtl/sar_start_edge.sv
module sar_start_edge (
    input  logic clk,
    input  logic rst,
    input  logic conv_start,
    output logic lead,
    output logic trail
);
    typedef struct packed {
        logic level;
    } edge_t;

    edge_t e_d, e_q;

    always_comb begin
        e_d       = e_q;
        e_d.level = conv_start;
        lead      = conv_start & ~e_q.level;
        trail     = ~conv_start & e_q.level;
    end

    always_ff @(posedge clk) begin
        if (rst) e_q <= '0;
        else     e_q <= e_d;
    end
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
    import sar_ctrl_pkg::*;
#(
    parameter int WIDTH   = 12,
    parameter int SHORT_A = 10,
    parameter int SHORT_B = 8,
    parameter int CW      = $clog2(WIDTH + 2)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lead,
    input  logic          trail,
    input  logic          step_en,
    input  logic [1:0]    res_sel,
    output logic          busy,
    output logic          init,
    output logic          step,
    output logic [CW-1:0] step_idx,
    output logic [CW-1:0] nbits
);
    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] cnt;
        logic [CW-1:0] nbits;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        init = 1'b0;
        step = 1'b0;
        case (s_q.phase)
            PH_IDLE: begin
                if (lead) begin
                    init      = 1'b1;
                    s_d.phase = PH_ARMED;
                    s_d.cnt   = '0;
                    s_d.nbits = CW'(res_bits(res_sel, WIDTH, SHORT_A, SHORT_B));
                end
            end
            PH_ARMED: begin
                if (trail) s_d.phase = PH_RUN;
            end
            PH_RUN: begin
                if (step_en) begin
                    step    = 1'b1;
                    s_d.cnt = s_q.cnt + 1'b1;
                    if (s_q.cnt == s_q.nbits) s_d.phase = PH_SETTLE;
                end
            end
            PH_SETTLE: s_d.phase = PH_IDLE;
            default:   s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.phase <= PH_IDLE;
            s_q.cnt   <= '0;
            s_q.nbits <= CW'(WIDTH);
        end else begin
            s_q <= s_d;
        end
    end

    assign busy     = (s_q.phase != PH_IDLE);
    assign step_idx = s_q.cnt;
    assign nbits    = s_q.nbits;
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
    parameter int WIDTH = 12,
    parameter int CW    = $clog2(WIDTH + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init,
    input  logic             step,
    input  logic [CW-1:0]    step_idx,
    input  logic [CW-1:0]    nbits,
    input  logic             cmp_keep,
    output logic [WIDTH-1:0] trial,
    output logic             dec_valid,
    output logic             dec_bit
);
    typedef struct packed {
        logic [WIDTH-1:0] word;
    } trial_t;

    trial_t t_d, t_q;

    always_comb begin
        t_d       = t_q;
        dec_valid = step && (step_idx != '0);
        dec_bit   = cmp_keep;
        if (init) begin
            t_d.word = '0;
        end else if (step) begin
            for (int b = 0; b < WIDTH; b++) begin
                if (step_idx == '0) begin
                    t_d.word[b] = (b == WIDTH - 1);
                end else begin
                    // decision on the pending bit
                    if (b == WIDTH - int'(step_idx) && !cmp_keep)
                        t_d.word[b] = 1'b0;
                    // next lower bit goes into trial while bits remain
                    if (b == WIDTH - 1 - int'(step_idx) && step_idx < nbits)
                        t_d.word[b] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) t_q <= '0;
        else     t_q <= t_d;
    end

    assign trial = t_q.word;
endmodule

// File: rtl/sar_out_stage.sv
module sar_out_stage (
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic dec_valid,
    input  logic dec_bit,
    output logic conv_clk,
    output logic ser_out
);
    typedef struct packed {
        logic cclk;
        logic ser;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d      = o_q;
        o_d.cclk = step;
        if (step) o_d.ser = dec_valid ? ~dec_bit : 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_q.cclk <= 1'b0;
            o_q.ser  <= 1'b1;
        end else begin
            o_q <= o_d;
        end
    end

    assign conv_clk = o_q.cclk;
    assign ser_out  = o_q.ser;
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
    parameter int WIDTH   = 12,
    parameter int SHORT_A = 10,
    parameter int SHORT_B = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_start,
    input  logic             step_en,
    input  logic             cmp_keep,
    input  logic [1:0]       res_sel,
    output logic [WIDTH-1:0] trial,
    output logic             busy,
    output logic             conv_clk,
    output logic             ser_out,
    output logic [WIDTH-1:0] par_out
);
    localparam int CW = $clog2(WIDTH + 2);

    logic          lead, trail, init, step, dec_valid, dec_bit;
    logic [CW-1:0] step_idx, nbits;

    sar_start_edge u_edge (
        .clk(clk), .rst(rst), .conv_start(conv_start),
        .lead(lead), .trail(trail)
    );

    sar_sequencer #(.WIDTH(WIDTH), .SHORT_A(SHORT_A), .SHORT_B(SHORT_B), .CW(CW)) u_seq (
        .clk(clk), .rst(rst), .lead(lead), .trail(trail), .step_en(step_en),
        .res_sel(res_sel), .busy(busy), .init(init), .step(step),
        .step_idx(step_idx), .nbits(nbits)
    );

    sar_trial_reg #(.WIDTH(WIDTH), .CW(CW)) u_trial (
        .clk(clk), .rst(rst), .init(init), .step(step), .step_idx(step_idx),
        .nbits(nbits), .cmp_keep(cmp_keep), .trial(trial),
        .dec_valid(dec_valid), .dec_bit(dec_bit)
    );

    sar_out_stage u_out (
        .clk(clk), .rst(rst), .step(step), .dec_valid(dec_valid),
        .dec_bit(dec_bit), .conv_clk(conv_clk), .ser_out(ser_out)
    );

    assign par_out = ~trial;
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
    parameter int WIDTH = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             conv_start,
    input logic             busy,
    input logic             conv_clk,
    input logic             ser_out,
    input logic [WIDTH-1:0] trial,
    input logic [WIDTH-1:0] par_out
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!busy && !conv_clk && ser_out && trial == '0 && par_out == '1));

    // R2
    start_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(conv_start) && trial == '0 && par_out == '1));

    // R3
    idle_clk_low_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !conv_clk);

    // R6
    ser_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!conv_clk && !$past(rst)) |-> $stable(ser_out));

    // R8
    settle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(conv_clk) && $stable(par_out)));
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst(rst), .conv_start(conv_start), .busy(busy),
    .conv_clk(conv_clk), .ser_out(ser_out), .trial(trial), .par_out(par_out)
);

// File: tb/sar_conv_ctrl_test.sv
`timescale 1ns/1ps
module sar_conv_ctrl_test;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         conv_start = 1'b0;
    logic         step_en = 1'b0;
    logic         cmp_keep;
    logic [1:0]   res_sel = 2'b00;
    logic [W-1:0] trial, par_out;
    logic         busy, conv_clk, ser_out;
    logic [W-1:0] vin = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    sar_conv_ctrl uut (
        .clk(clk), .rst(rst), .conv_start(conv_start), .step_en(step_en),
        .cmp_keep(cmp_keep), .res_sel(res_sel), .trial(trial), .busy(busy),
        .conv_clk(conv_clk), .ser_out(ser_out), .par_out(par_out)
    );

    // ideal comparator against the DAC driven by the trial word
    assign cmp_keep = (vin >= trial);

    always #2.5 clk = ~clk;

    always @(negedge clk) step_en <= ($urandom_range(0, 2) == 0);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_bits(input logic [1:0] sel);
        if (sel == 2'b01) return 10;
        if (sel == 2'b10) return 8;
        return 12;
    endfunction

    function automatic logic [W-1:0] exp_code(input logic [W-1:0] v, input logic [1:0] sel);
        int nb = exp_bits(sel);
        logic [W-1:0] mask = W'(((1 << nb) - 1) << (W - nb));
        return v & mask;
    endfunction

    // poke: 0 none, 1 request pulse mid-run, 2 request raised at last pulse
    task automatic run_conv(input logic [W-1:0] v, input logic [1:0] sel, input int poke);
        int nb = exp_bits(sel);
        logic [W-1:0] code = exp_code(v, sel);
        logic [W-1:0] last_par = '0;
        int pulses = 0;
        int gap = 0;
        int guard = 0;
        string rq = (nb == W) ? "R5" : "R7";
        @(negedge clk);
        vin = v; res_sel = sel; conv_start = 1'b1;
        @(negedge clk);
        chk(busy && par_out == '1 && trial == '0, "R2 busy on request", int'(busy), 1);
        res_sel = 2'($urandom);   // later changes must not matter (R7)
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!conv_clk && trial == '0, "R10 armed ticks ignored", int'(trial), 0);
        end
        conv_start = 1'b0;
        while (busy && guard < 2000) begin
            @(negedge clk);
            guard++;
            if (conv_clk) begin
                pulses++;
                gap = 0;
                last_par = par_out;
                if (pulses == 1) begin
                    chk(trial == W'(1 << (W - 1)), "R4 msb trial", int'(trial), 1 << (W - 1));
                    chk(ser_out == 1'b1, "R6 first serial bit", int'(ser_out), 1);
                end else if (pulses <= nb + 1) begin
                    chk(ser_out == ~code[W - pulses + 1], "R6 serial bit",
                        int'(ser_out), int'(~code[W - pulses + 1]));
                end
                if (poke == 1 && pulses == 3) conv_start = 1'b1;
                if (poke == 1 && pulses == 5) conv_start = 1'b0;
                if (poke == 2 && pulses == nb + 1) conv_start = 1'b1;
            end else begin
                gap++;
            end
        end
        chk(pulses == nb + 1, "R3 pulse count", pulses, nb + 1);
        chk(gap == 1 && last_par == par_out, "R8 busy fall one cycle after last pulse", gap, 1);
        chk(par_out == ~code, rq, int'(par_out), int'(~code));
        if (poke != 0)
            chk(par_out == ~code, "R9 result with request while busy", int'(par_out), int'(~code));
        if (poke == 2) begin
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                chk(!busy && !conv_clk, "R9 no restart from late request", int'(busy), 0);
            end
            conv_start = 1'b0;
        end
        @(negedge clk);
        chk(!conv_clk && !busy, "R3 clock low when idle", int'(conv_clk), 0);
        chk(ser_out == ~code[W - nb], "R6 serial holds last bit", int'(ser_out), int'(~code[W - nb]));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        chk(!busy && !conv_clk && trial == '0 && par_out == '1 && ser_out,
            "R1 state in reset", int'(par_out), 'hfff);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !conv_clk && trial == '0 && par_out == '1 && ser_out,
            "R1 state after reset", int'(par_out), 'hfff);

        run_conv(12'h000, 2'b00, 0);
        run_conv(12'hfff, 2'b00, 0);
        run_conv(12'h800, 2'b00, 0);
        run_conv(12'h7ff, 2'b00, 0);
        run_conv(12'h001, 2'b00, 0);
        run_conv(12'h676, 2'b11, 0);
        run_conv(12'hfff, 2'b01, 0);
        run_conv(12'h803, 2'b01, 0);
        run_conv(12'hfff, 2'b10, 0);
        run_conv(12'h5a5, 2'b10, 0);
        run_conv(12'h9c3, 2'b00, 1);
        run_conv(12'h3c7, 2'b00, 2);
        run_conv(12'h0ff, 2'b10, 2);
        for (int n = 0; n < 40; n++) begin
            run_conv(W'($urandom), 2'($urandom), int'($urandom_range(0, 2)));
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule